// File: doc/BRIEF.md
# Wake-Up Detector with Source Latch

This block watches for wake-up events while the system basis chip is in a low-power mode, holds the resulting request, and reports where the request came from. A local wake arrives on the active-low `wake_n_i` pin. A remote wake arrives on `bus_rx_i`, which is the digitized output of the LIN bus receiver: 1 means recessive and 0 means dominant. Both inputs may change asynchronously, so each passes through a synchronizer chain first. The wake pin then goes through a deglitch filter.

A local wake fires on a filtered falling edge of the wake pin. Because of this, the device can enter sleep with the pin already held low without waking at once. A remote wake needs a complete dominant pulse on the bus: a falling edge, a dominant level that lasts at least `HOLD_TICKS` cycles, and then the return to recessive.

The first event that occurs is latched as a request together with its source. The request is visible to the mode controller at all times. On the RXD and TXD pins it is presented only in power-on and standby, and only while EN is low. Entering active mode clears the request and its source.

The block has only control and status pins. No data stream passes through it, so it has no valid/ready handshake and no back-pressure.

Top module: `wkup_detect`

## Requirements
- R1: While reset is asserted, and directly after it, `wake_req_o` is 0, `wake_remote_o` is 0, `rxd_low_o` is 0 and `txd_src_o` is 2'b00.
- R2: A local wake is raised by a falling edge of the filtered wake pin while detection is enabled. A wake pin that is already low when detection starts, or that stays low, raises no wake. A later rise followed by a new fall does raise one.
- R3: A low level on `wake_n_i` that lasts fewer than `DEB_TICKS` consecutive synchronized samples is ignored. The filtered level changes only after `DEB_TICKS` consecutive samples of the new value.
- R4: A remote wake is raised when the synchronized bus goes recessive after a dominant stretch of at least `HOLD_TICKS` cycles, and that stretch must have begun with a falling edge seen while detection was enabled. A shorter stretch raises no wake. A bus that was already dominant when detection started raises no wake.
- R5: Wake detection is enabled only when `mode_i` is sleep (3'd4) or standby (3'd3). The other mode codes are off (0), power-on (1), active (2) and flash (5), and in those modes no event sets the request.
- R6: `rxd_low_o` is 1 exactly when a request is latched, `mode_i` is power-on or standby, and `en_i` is 0.
- R7: `txd_src_o` is 2'b01 (weak pull-up) for a remote source and 2'b10 (strong pull-down) for a local source, under the same condition as `rxd_low_o`. Otherwise it is 2'b00 (released). `wake_remote_o` is 1 for a remote source.
- R8: `wake_req_o` and `wake_remote_o` clear on the clock edge that samples `mode_i` as active.
- R9: While `en_i` is 1, RXD and TXD signalling is suspended, and the latched request and source are kept.
- R10: Once a request is latched, its source does not change until it is cleared. If a local and a remote event fall in the same cycle, the local source wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Current mode code (see R5) |
| en_i | input | 1 | Enable pin level; when high, wake signalling is suspended |
| wake_n_i | input | 1 | Local wake pin, active low, asynchronous |
| bus_rx_i | input | 1 | Digitized bus level, 1 = recessive, asynchronous |
| wake_req_o | output | 1 | Latched wake request for the mode controller |
| wake_remote_o | output | 1 | Latched source, 1 = remote, 0 = local |
| rxd_low_o | output | 1 | Request to pull RXD low |
| txd_src_o | output | 2 | TXD drive code: 00 released, 01 weak high, 10 strong low |

## Verification
The assertions assume that `mode_i` and `en_i` are synchronous to `clk` and hold one of the six legal mode codes. They also assume that the mode controller moves to active mode to clear a request, since nothing else clears it. The stimulus meets these assumptions: it changes every input one nanosecond after a rising edge and uses only the defined mode codes. It does feed the wake pin and the bus with pulses that are shorter, exactly as long, and longer than the filter and hold windows, so the edge-triggered and duration-qualified paths are exercised at their limits.

// File: rtl/wkup_pkg.sv
`timescale 1ns/1ps
package wkup_pkg;
  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_PON    = 3'd1,
    MODE_ACTIVE = 3'd2,
    MODE_STBY   = 3'd3,
    MODE_SLEEP  = 3'd4,
    MODE_FLASH  = 3'd5
  } sbc_mode_e;

  typedef enum logic [1:0] {
    DRV_RELEASE   = 2'b00,
    DRV_WEAK_HI   = 2'b01,
    DRV_STRONG_LO = 2'b10
  } pin_drv_e;
endpackage

// File: rtl/wkup_sync.sv
`timescale 1ns/1ps
module wkup_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/wkup_deglitch.sv
`timescale 1ns/1ps
module wkup_deglitch #(
  parameter int TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic fell_o
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          filt_q;
  logic          prev_q;
  logic [CW-1:0] cnt_q;

  // The filtered level follows the raw input only after TICKS equal samples in a row.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b1;
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      prev_q <= filt_q;
      if (raw_i != filt_q) begin
        if (cnt_q == LAST) begin
          filt_q <= raw_i;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign level_o = filt_q;
  assign fell_o  = prev_q & ~filt_q;
endmodule

// File: rtl/wkup_dom_qual.sv
`timescale 1ns/1ps
module wkup_dom_qual #(
  parameter int HOLD_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic bus_i,
  output logic evt_o
);
  localparam int CW = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] HOLD = CW'(HOLD_TICKS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          prev_q;
  logic          armed_q;
  logic [CW-1:0] low_cnt_q;
  logic          fell;
  logic          rise;

  assign fell  = prev_q & ~bus_i;
  assign rise  = ~prev_q & bus_i;
  assign evt_o = enable_i & armed_q & rise & (low_cnt_q >= HOLD);

  // A stretch is armed only by a falling edge seen while detection is enabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b1;
      armed_q   <= 1'b0;
      low_cnt_q <= '0;
    end else begin
      prev_q <= bus_i;
      if (!enable_i) begin
        armed_q   <= 1'b0;
        low_cnt_q <= '0;
      end else if (fell) begin
        armed_q   <= 1'b1;
        low_cnt_q <= ONE;
      end else if (rise) begin
        armed_q   <= 1'b0;
        low_cnt_q <= '0;
      end else if (armed_q && !bus_i && (low_cnt_q != HOLD)) begin
        low_cnt_q <= low_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wkup_flag_latch.sv
`timescale 1ns/1ps
module wkup_flag_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic loc_evt_i,
  input  logic rem_evt_i,
  output logic req_o,
  output logic remote_o
);
  logic req_q;
  logic remote_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      remote_q <= 1'b0;
    end else if (clear_i) begin
      req_q    <= 1'b0;
      remote_q <= 1'b0;
    end else if (!req_q && (loc_evt_i || rem_evt_i)) begin
      req_q    <= 1'b1;
      remote_q <= ~loc_evt_i;
    end
  end

  assign req_o    = req_q;
  assign remote_o = remote_q;
endmodule

// File: rtl/wkup_detect.sv
`timescale 1ns/1ps
module wkup_detect
  import wkup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_TICKS   = 8,
  parameter int HOLD_TICKS  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       en_i,
  input  logic       wake_n_i,
  input  logic       bus_rx_i,
  output logic       wake_req_o,
  output logic       wake_remote_o,
  output logic       rxd_low_o,
  output logic [1:0] txd_src_o
);
  sbc_mode_e mode;
  logic      det_en;
  logic      report;
  logic      wake_s;
  logic      bus_s;
  logic      wake_lvl;
  logic      wake_fell;
  logic      loc_evt;
  logic      rem_evt;
  pin_drv_e  txd_drv;

  assign mode   = sbc_mode_e'(mode_i);
  assign det_en = (mode == MODE_SLEEP) || (mode == MODE_STBY);

  wkup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_wake (
    .clk(clk), .rst_n(rst_n), .d_i(wake_n_i), .q_o(wake_s)
  );

  wkup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d_i(bus_rx_i), .q_o(bus_s)
  );

  wkup_deglitch #(.TICKS(DEB_TICKS)) u_wake_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(wake_s),
    .level_o(wake_lvl), .fell_o(wake_fell)
  );

  assign loc_evt = det_en & wake_fell;

  wkup_dom_qual #(.HOLD_TICKS(HOLD_TICKS)) u_bus_qual (
    .clk(clk), .rst_n(rst_n), .enable_i(det_en), .bus_i(bus_s), .evt_o(rem_evt)
  );

  wkup_flag_latch u_latch (
    .clk(clk), .rst_n(rst_n), .clear_i(mode == MODE_ACTIVE),
    .loc_evt_i(loc_evt), .rem_evt_i(rem_evt),
    .req_o(wake_req_o), .remote_o(wake_remote_o)
  );

  assign report = wake_req_o & ~en_i & ((mode == MODE_PON) || (mode == MODE_STBY));

  always_comb begin
    if (!report)           txd_drv = DRV_RELEASE;
    else if (wake_remote_o) txd_drv = DRV_WEAK_HI;
    else                   txd_drv = DRV_STRONG_LO;
  end

  assign rxd_low_o = report;
  assign txd_src_o = txd_drv;

  logic unused_lvl;
  assign unused_lvl = wake_lvl;
endmodule

// File: rtl/wkup_detect_chk.sv
`timescale 1ns/1ps
module wkup_detect_chk
  import wkup_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic       en_i,
  input logic       wake_n_i,
  input logic       bus_rx_i,
  input logic       wake_req_o,
  input logic       wake_remote_o,
  input logic       rxd_low_o,
  input logic [1:0] txd_src_o
);
  assert_clear_on_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_ACTIVE) |=> (!wake_req_o && !wake_remote_o));

  assert_set_only_when_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req_o) |-> (($past(mode_i) == MODE_SLEEP) || ($past(mode_i) == MODE_STBY)));

  assert_rxd_needs_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_low_o |-> (wake_req_o && !en_i));

  assert_en_suspends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (!rxd_low_o && (txd_src_o == DRV_RELEASE)));

  assert_txd_follows_rxd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_src_o != DRV_RELEASE) == rxd_low_o);

  assert_legal_drive_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    txd_src_o != 2'b11);

  assert_source_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req_o && (mode_i != MODE_ACTIVE)) |=> (wake_req_o && $stable(wake_remote_o)));

  assert_source_implies_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_remote_o |-> wake_req_o);

  logic unused_in;
  assign unused_in = wake_n_i ^ bus_rx_i;
endmodule

bind wkup_detect wkup_detect_chk chk_i (.*);

// File: tb/wkup_detect_tb_top.sv
`timescale 1ns/1ps
module wkup_detect_tb_top;
  import wkup_pkg::*;

  localparam int S = 2;
  localparam int D = 8;
  localparam int H = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = MODE_PON;
  logic       en = 1'b0;
  logic       wake_n = 1'b1;
  logic       bus = 1'b1;
  logic       wake_req_o, wake_remote_o, rxd_low_o;
  logic [1:0] txd_src_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  wkup_detect #(.SYNC_STAGES(S), .DEB_TICKS(D), .HOLD_TICKS(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .en_i(en), .wake_n_i(wake_n),
    .bus_rx_i(bus), .wake_req_o(wake_req_o), .wake_remote_o(wake_remote_o),
    .rxd_low_o(rxd_low_o), .txd_src_o(txd_src_o)
  );

  // Behavioural reference: delay lines, run-length counters, flags.
  bit m_wq[$];
  bit m_bq[$];
  bit m_req, m_src, m_wfilt, m_wprev, m_bprev, m_armed;
  int m_low, m_mis;
  bit ws, bs, det, loc, fell, rise, rem;

  task automatic model_reset();
    m_wq = {};
    m_bq = {};
    for (int i = 0; i < S; i++) begin m_wq.push_back(1'b1); m_bq.push_back(1'b1); end
    m_req = 0; m_src = 0; m_wfilt = 1; m_wprev = 1; m_bprev = 1; m_armed = 0;
    m_low = 0; m_mis = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      ws   = m_wq[S-1];
      bs   = m_bq[S-1];
      det  = (mode == MODE_SLEEP) || (mode == MODE_STBY);
      loc  = det && m_wprev && !m_wfilt;
      fell = m_bprev && !bs;
      rise = !m_bprev && bs;
      rem  = det && m_armed && rise && (m_low >= H);
      if (mode == MODE_ACTIVE) begin m_req = 0; m_src = 0; end
      else if (!m_req && (loc || rem)) begin m_req = 1; m_src = !loc; end
      if (!det) begin m_armed = 0; m_low = 0; end
      else if (fell) begin m_armed = 1; m_low = 1; end
      else if (rise) begin m_armed = 0; m_low = 0; end
      else if (m_armed && !bs && m_low < H) m_low++;
      m_wprev = m_wfilt;
      m_bprev = bs;
      if (ws != m_wfilt) begin
        m_mis++;
        if (m_mis >= D) begin m_wfilt = ws; m_mis = 0; end
      end else m_mis = 0;
      void'(m_wq.pop_back()); m_wq.push_front(wake_n);
      void'(m_bq.pop_back()); m_bq.push_front(bus);
    end
  end

  function automatic bit exp_rxd();
    return m_req && !en && ((mode == MODE_PON) || (mode == MODE_STBY));
  endfunction

  function automatic logic [1:0] exp_txd();
    if (!exp_rxd()) return 2'b00;
    return m_src ? 2'b01 : 2'b10;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(wake_req_o == m_req, "R8 per-cycle wake_req_o", wake_req_o, m_req);
    chk(wake_remote_o == m_src, "R10 per-cycle wake_remote_o", wake_remote_o, m_src);
    chk(rxd_low_o == exp_rxd(), "R6 per-cycle rxd_low_o", rxd_low_o, exp_rxd());
    chk(txd_src_o == exp_txd(), "R7 per-cycle txd_src_o", txd_src_o, exp_txd());
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_pulse(input int n);
    bus = 1'b0; tick(n); bus = 1'b1; tick(8);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    tick(3);
    chk(!wake_req_o && !rxd_low_o && txd_src_o == 2'b00, "R1 in reset", wake_req_o, 0);
    rst_n = 1'b1;
    tick(2);
    chk(!wake_req_o && !wake_remote_o, "R1 after reset", wake_req_o, 0);

    // Local wake in sleep, then reported in power-on
    mode = MODE_SLEEP; tick(5);
    wake_n = 1'b0; tick(15); wake_n = 1'b1; tick(15);
    chk(wake_req_o == 1'b1, "R2 local fall in sleep", wake_req_o, 1);
    mode = MODE_PON; tick(1);
    chk(rxd_low_o == 1'b1, "R6 rxd in power-on", rxd_low_o, 1);
    chk(txd_src_o == 2'b10, "R7 local strong low", txd_src_o, 2);
    en = 1'b1; tick(1);
    chk(rxd_low_o == 1'b0 && txd_src_o == 2'b00, "R9 en suspends", txd_src_o, 0);
    chk(wake_req_o == 1'b1, "R9 request kept under en", wake_req_o, 1);
    en = 1'b0; mode = MODE_ACTIVE; tick(2);
    chk(wake_req_o == 1'b0, "R8 cleared in active", wake_req_o, 0);

    // Short glitch in standby
    mode = MODE_STBY; tick(3);
    wake_n = 1'b0; tick(D - 2); wake_n = 1'b1; tick(20);
    chk(wake_req_o == 1'b0, "R3 short glitch ignored", wake_req_o, 0);

    // Sleep entered with pin already low
    mode = MODE_ACTIVE; wake_n = 1'b0; tick(20);
    mode = MODE_SLEEP; tick(40);
    chk(wake_req_o == 1'b0, "R2 held low no wake", wake_req_o, 0);
    wake_n = 1'b1; tick(15); wake_n = 1'b0; tick(20);
    chk(wake_req_o == 1'b1, "R2 new fall wakes", wake_req_o, 1);
    wake_n = 1'b1; mode = MODE_ACTIVE; tick(15);

    // Remote wakes in standby
    mode = MODE_STBY; tick(3);
    bus_pulse(H - 5);
    chk(wake_req_o == 1'b0, "R4 short dominant ignored", wake_req_o, 0);
    bus_pulse(H + 10);
    chk(wake_req_o == 1'b1 && wake_remote_o == 1'b1, "R4 long dominant wakes", wake_remote_o, 1);
    chk(txd_src_o == 2'b01, "R7 remote weak high", txd_src_o, 1);
    wake_n = 1'b0; tick(20);
    chk(txd_src_o == 2'b01, "R10 remote kept over local", txd_src_o, 1);
    wake_n = 1'b1; tick(15);
    mode = MODE_ACTIVE; tick(3);

    // Events outside detection modes
    mode = MODE_FLASH; tick(3);
    wake_n = 1'b0; tick(20); wake_n = 1'b1; tick(15);
    bus_pulse(H + 10);
    chk(wake_req_o == 1'b0, "R5 no wake in flash", wake_req_o, 0);
    mode = MODE_PON; tick(3);
    wake_n = 1'b0; tick(20); wake_n = 1'b1; tick(15);
    chk(wake_req_o == 1'b0, "R5 no wake in power-on", wake_req_o, 0);

    // Local first, then remote
    mode = MODE_STBY; tick(3);
    wake_n = 1'b0; tick(20);
    chk(txd_src_o == 2'b10, "R7 local in standby", txd_src_o, 2);
    bus_pulse(H + 10);
    chk(txd_src_o == 2'b10 && wake_remote_o == 1'b0, "R10 local kept over remote", txd_src_o, 2);
    wake_n = 1'b1; mode = MODE_ACTIVE; tick(15);

    // Bus dominant before sleep
    bus = 1'b0; tick(5);
    mode = MODE_SLEEP; tick(40);
    bus = 1'b1; tick(10);
    chk(wake_req_o == 1'b0, "R4 no arming without fall", wake_req_o, 0);
    bus_pulse(H);
    chk(wake_req_o == 1'b1 && wake_remote_o == 1'b1, "R4 exact hold wakes", wake_req_o, 1);

    tick(5);
    finish_run();
  end
endmodule